// File: doc/BRIEF.md
# Text-Cell Row Store with Scroll

This block holds the character contents of a small auxiliary text display. The store is organised as four logical rows of thirty-two cells, and each cell holds one 8-bit glyph code. A command source sends commands through a valid/ready handshake. A command can place a run of glyphs into part of a row, shift a row left or right, flood a row with one glyph, or blank one row or every row. Every parameter is range-checked before anything is changed. A command that fails the check leaves all cells as they were and produces a one-cycle error strobe.

A display driver reads any row through a combinational read port. The block keeps one dirty flag per row, and a flag is raised only when a command really alters that row's cells. The driver refreshes only the flagged rows and clears each flag with a per-row acknowledge.

The glyphs of a write command arrive one per cycle after its header. They are collected in a staging buffer and committed together. A reserved glyph anywhere in the run therefore rejects the whole command.

Top module: `glyph_row_store`

## Requirements
- R1: After a synchronous active-low reset every cell holds 0x20 (space), all dirty flags are 0, `cmd_ready` is 1 and `glyph_ready` is 0.
- R2: Opcode 0 (write run) takes row in `cmd_row`, start column in `cmd_arg0` and glyph count in `cmd_arg1`. It then accepts that many glyphs on the glyph stream and writes them to consecutive cells from the start column. The new contents are visible one cycle after the last glyph is accepted. Cells outside the span are unchanged. A count of 0 is legal and changes nothing.
- R3: A write run whose start column exceeds 31, whose count exceeds 32, or whose start plus count exceeds 32 is rejected at the header. No glyph is consumed and `cmd_ready` stays 1.
- R4: Opcode 1 (scroll) with `cmd_arg0` = 0 shifts the row toward column 0 by `cmd_arg1` cells, so cell c takes cell c+N and the vacated high cells become 0x20. With `cmd_arg0` = 1 it shifts toward column 31, so cell c takes cell c−N and the vacated low cells become 0x20.
- R5: The scroll amount must be 1 to 32, and 32 blanks the row. An amount of 0 or above 32, or a direction code other than 0 or 1, is an error.
- R6: Opcode 2 (fill) writes the glyph in `cmd_arg0` to all 32 cells of the row. A fill glyph of 0x7F or above is an error.
- R7: Opcode 3 (clear) writes 0x20 to every cell of the row. Row code 0xFF with this opcode clears all four rows.
- R8: Row codes 1 to 4 select rows, read back as `rd_sel` 0 to 3. Row 0, rows above 4, and 0xFF with any opcode other than clear are errors.
- R9: If any streamed glyph of a write run is 0x7F or above, the whole run is rejected after its last glyph. No cell changes and the error strobe rises.
- R10: A rejected command changes no cell. `err_pulse` is high for exactly one cycle, in the cycle after the rejecting edge, and the block is then ready for a new command.
- R11: A row's dirty flag is set only when a command changes at least one cell of that row. `dirty_ack[r]` clears it, and a change in the same cycle as an acknowledge leaves the flag set.
- R12: While a write run is streaming, `cmd_ready` is 0 and `glyph_ready` is 1. At all other times `glyph_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command header valid |
| cmd_ready | output | 1 | Block can accept a header |
| cmd_op | input | 2 | 0 write run, 1 scroll, 2 fill, 3 clear |
| cmd_row | input | 8 | Logical row 1..4, or 0xFF for clear-all |
| cmd_arg0 | input | 8 | Start column, direction or fill glyph |
| cmd_arg1 | input | 8 | Glyph count or scroll amount |
| glyph_valid | input | 1 | Streamed glyph valid |
| glyph_ready | output | 1 | Block is taking glyphs of a write run |
| glyph_data | input | 8 | Streamed glyph code |
| err_pulse | output | 1 | One-cycle rejection strobe |
| dirty | output | 4 | Per-row changed flags |
| dirty_ack | input | 4 | Per-row flag clear from the display driver |
| rd_sel | input | 2 | Row index for readback (row code minus one) |
| rd_cells | output | 256 | Selected row, cell c at bits [8c+7:8c] |

## Verification
On every cycle the assertions check that the two handshakes are never ready together and that the store holds still while glyphs are streaming. They also check that an error strobe coincides with an unchanged store and an idle block, that a dirty flag rises only together with a store change, and that an acknowledged row with no new change drops its flag. Whether the cells end up with the right values can only be shown by the bench's scenarios. This covers the exact contents after each write, the direction and fill of a scroll, the clear-all code, the rejection of each out-of-range field, and a reserved glyph in the middle of a run.

// File: rtl/grs_pkg.sv
// Shared types and constants for the text-cell row store.
// Assumes 8-bit glyph codes; the constants are cast to the glyph width at use.
package grs_pkg;

    // Opcodes carried on cmd_op.
    typedef enum logic [1:0] {
        OP_WRITE  = 2'd0,
        OP_SCROLL = 2'd1,
        OP_FILL   = 2'd2,
        OP_CLEAR  = 2'd3
    } cmd_op_e;

    // Row transformation applied by the per-row datapath.
    typedef enum logic [1:0] {
        XF_NONE  = 2'd0,
        XF_SPAN  = 2'd1,
        XF_SHIFT = 2'd2,
        XF_FLOOD = 2'd3
    } xform_e;

    localparam logic [7:0] BLANK_GLYPH    = 8'h20;
    localparam logic [7:0] FIRST_RESERVED = 8'h7F;
    localparam logic [7:0] EVERY_ROW      = 8'hFF;

endpackage

// File: rtl/grs_cmd_ctrl.sv
// Command front end: accepts headers, validates every field, stages the
// glyphs of a write run and issues one apply request per legal command.
// Assumes a write run's glyphs follow its header; a header that fails
// validation consumes no glyphs. Errors strobe one cycle after the edge
// that rejects the command.
module grs_cmd_ctrl
    import grs_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 32,
    parameter int GW   = 8,
    parameter int FW   = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [1:0]             cmd_op,
    input  logic [FW-1:0]          cmd_row,
    input  logic [FW-1:0]          cmd_arg0,
    input  logic [FW-1:0]          cmd_arg1,
    input  logic                   glyph_valid,
    output logic                   glyph_ready,
    input  logic [GW-1:0]          glyph_data,
    output logic                   err_pulse,
    output logic                   apply_en,
    output logic [ROWS-1:0]        apply_mask,
    output xform_e                 apply_kind,
    output logic [$clog2(COLS):0]  apply_a,
    output logic [$clog2(COLS):0]  apply_b,
    output logic                   apply_dir,
    output logic [GW-1:0]          apply_glyph,
    output logic [COLS*GW-1:0]     apply_run
);

    localparam int CW = $clog2(COLS);
    localparam int NW = CW + 1;
    localparam logic [GW-1:0] RSV = GW'(FIRST_RESERVED);
    localparam logic [GW-1:0] SPC = GW'(BLANK_GLYPH);

    typedef enum logic [1:0] {S_IDLE, S_STREAM, S_COMMIT} state_e;

    state_e          state_q;
    logic [ROWS-1:0] row_q;
    logic [NW-1:0]   col_q;
    logic [NW-1:0]   cnt_q;
    logic [NW-1:0]   len_q;
    logic            bad_q;
    logic            err_q;
    logic [GW-1:0]   stage_q [COLS];

    logic            fire;
    logic            gfire;
    logic            hdr_ok;
    logic            row_ok;
    logic            all_rows;
    logic [ROWS-1:0] row_onehot;
    logic [CW-1:0]   wr_pos;

    assign cmd_ready   = (state_q == S_IDLE);
    assign glyph_ready = (state_q == S_STREAM);
    assign fire        = cmd_valid && cmd_ready;
    assign gfire       = glyph_valid && glyph_ready;
    assign err_pulse   = err_q;
    assign wr_pos      = col_q[CW-1:0] + cnt_q[CW-1:0];

    // Decode the row code into a one-hot row select.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            row_onehot[r] = (cmd_row == FW'(r + 1));
        end
        row_ok   = |row_onehot;
        all_rows = (cmd_row == FW'(EVERY_ROW));
    end

    // Validate the header fields for the requested opcode.
    always_comb begin
        case (cmd_op_e'(cmd_op))
            OP_WRITE:  hdr_ok = row_ok
                              && (cmd_arg0 < FW'(COLS))
                              && (cmd_arg1 <= FW'(COLS))
                              && ((FW+1)'(cmd_arg0) + (FW+1)'(cmd_arg1) <= (FW+1)'(COLS));
            OP_SCROLL: hdr_ok = row_ok
                              && (cmd_arg0 <= FW'(1))
                              && (cmd_arg1 != '0)
                              && (cmd_arg1 <= FW'(COLS));
            OP_FILL:   hdr_ok = row_ok && (cmd_arg0[GW-1:0] < RSV) && (cmd_arg0 < FW'(RSV));
            default:   hdr_ok = row_ok || all_rows;
        endcase
    end

    // Present the staged run as a flat row image.
    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            apply_run[c*GW +: GW] = stage_q[c];
        end
    end

    // Build the apply request from either a direct header or a finished run.
    always_comb begin
        apply_en    = 1'b0;
        apply_mask  = row_onehot;
        apply_kind  = XF_NONE;
        apply_a     = '0;
        apply_b     = cmd_arg1[NW-1:0];
        apply_dir   = cmd_arg0[0];
        apply_glyph = cmd_arg0[GW-1:0];
        if (state_q == S_IDLE && fire && hdr_ok) begin
            case (cmd_op_e'(cmd_op))
                OP_SCROLL: begin
                    apply_en   = 1'b1;
                    apply_kind = XF_SHIFT;
                end
                OP_FILL: begin
                    apply_en   = 1'b1;
                    apply_kind = XF_FLOOD;
                end
                OP_CLEAR: begin
                    apply_en    = 1'b1;
                    apply_kind  = XF_FLOOD;
                    apply_glyph = SPC;
                    if (all_rows) apply_mask = '1;
                end
                default: apply_en = 1'b0;
            endcase
        end else if (state_q == S_COMMIT) begin
            apply_en   = !bad_q;
            apply_mask = row_q;
            apply_kind = XF_SPAN;
            apply_a    = col_q;
            apply_b    = len_q;
        end
    end

    // Sequence header, glyph stream and commit; raise the error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            cnt_q   <= '0;
            len_q   <= '0;
            bad_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (fire) begin
                        if (!hdr_ok) begin
                            err_q <= 1'b1;
                        end else if (cmd_op_e'(cmd_op) == OP_WRITE && cmd_arg1 != '0) begin
                            state_q <= S_STREAM;
                            row_q   <= row_onehot;
                            col_q   <= cmd_arg0[NW-1:0];
                            len_q   <= cmd_arg1[NW-1:0];
                            cnt_q   <= '0;
                            bad_q   <= 1'b0;
                        end
                    end
                end
                S_STREAM: begin
                    if (gfire) begin
                        cnt_q <= cnt_q + NW'(1);
                        if (glyph_data >= RSV) bad_q <= 1'b1;
                        if (cnt_q + NW'(1) == len_q) state_q <= S_COMMIT;
                    end
                end
                S_COMMIT: begin
                    err_q   <= bad_q;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Capture each streamed glyph at its destination column.
    always_ff @(posedge clk) begin
        if (gfire) stage_q[wr_pos] <= glyph_data;
    end

endmodule

// File: rtl/grs_row_xform.sv
// Combinational next-contents of one row for a given transformation.
// Assumes the caller already validated span, amount and glyph.
module grs_row_xform
    import grs_pkg::*;
#(
    parameter int COLS = 32,
    parameter int GW   = 8
) (
    input  logic [COLS*GW-1:0]    old_row,
    input  xform_e                kind,
    input  logic [$clog2(COLS):0] a,
    input  logic [$clog2(COLS):0] b,
    input  logic                  dir,
    input  logic [GW-1:0]         glyph,
    input  logic [COLS*GW-1:0]    run,
    output logic [COLS*GW-1:0]    new_row
);

    localparam int CW = $clog2(COLS);
    localparam int NW = CW + 1;
    localparam logic [GW-1:0] SPC = GW'(BLANK_GLYPH);

    logic [GW-1:0] cells [COLS];
    logic [NW:0]   pos;
    logic [NW:0]   src;

    // Unpack the current row into addressable cells.
    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            cells[c] = old_row[c*GW +: GW];
        end
    end

    // Compute each output cell for the selected transformation.
    always_comb begin
        new_row = old_row;
        pos     = '0;
        src     = '0;
        for (int c = 0; c < COLS; c++) begin
            pos = (NW+1)'(c);
            case (kind)
                XF_SPAN: begin
                    if (pos >= {1'b0, a} && pos < ({1'b0, a} + {1'b0, b}))
                        new_row[c*GW +: GW] = run[c*GW +: GW];
                end
                XF_FLOOD: new_row[c*GW +: GW] = glyph;
                XF_SHIFT: begin
                    if (!dir) begin
                        src = pos + {1'b0, b};
                        new_row[c*GW +: GW] = (src < (NW+1)'(COLS)) ? cells[src[CW-1:0]] : SPC;
                    end else begin
                        src = pos - {1'b0, b};
                        new_row[c*GW +: GW] = (pos >= {1'b0, b}) ? cells[src[CW-1:0]] : SPC;
                    end
                end
                default: new_row[c*GW +: GW] = cells[c];
            endcase
        end
    end

endmodule

// File: rtl/grs_row_bank.sv
// Row registers with one transformation datapath per row. A row loads
// only when it is selected and its computed contents differ.
// Assumes at most one apply request per cycle.
module grs_row_bank
    import grs_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 32,
    parameter int GW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     apply_en,
    input  logic [ROWS-1:0]          apply_mask,
    input  xform_e                   apply_kind,
    input  logic [$clog2(COLS):0]    apply_a,
    input  logic [$clog2(COLS):0]    apply_b,
    input  logic                     apply_dir,
    input  logic [GW-1:0]            apply_glyph,
    input  logic [COLS*GW-1:0]       apply_run,
    output logic [ROWS*COLS*GW-1:0]  rows_flat,
    output logic [ROWS-1:0]          changed
);

    localparam int RB = COLS * GW;
    localparam logic [GW-1:0] SPC = GW'(BLANK_GLYPH);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [RB-1:0] cur_q;
        logic [RB-1:0] nxt;

        grs_row_xform #(.COLS(COLS), .GW(GW)) u_xf (
            .old_row (cur_q),
            .kind    (apply_kind),
            .a       (apply_a),
            .b       (apply_b),
            .dir     (apply_dir),
            .glyph   (apply_glyph),
            .run     (apply_run),
            .new_row (nxt)
        );

        assign changed[r] = apply_en && apply_mask[r] && (nxt != cur_q);
        assign rows_flat[r*RB +: RB] = cur_q;

        // Hold the row, loading new contents only on a real change.
        always_ff @(posedge clk) begin
            if (!rst_n)          cur_q <= {COLS{SPC}};
            else if (changed[r]) cur_q <= nxt;
        end
    end

endmodule

// File: rtl/grs_dirty_track.sv
// Per-row dirty flags: set by a content change, cleared by acknowledge;
// a change in the acknowledge cycle keeps the flag set.
module grs_dirty_track #(
    parameter int ROWS = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] changed,
    input  logic [ROWS-1:0] ack,
    output logic [ROWS-1:0] dirty
);

    // Update the flags, giving priority to new changes.
    always_ff @(posedge clk) begin
        if (!rst_n) dirty <= '0;
        else        dirty <= (dirty & ~ack) | changed;
    end

endmodule

// File: rtl/glyph_row_store.sv
// Top of the text-cell row store: command front end, row bank, dirty
// tracking and a combinational row readback port for the display driver.
module glyph_row_store
    import grs_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 32,
    parameter int GW   = 8,
    parameter int FW   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [1:0]              cmd_op,
    input  logic [FW-1:0]           cmd_row,
    input  logic [FW-1:0]           cmd_arg0,
    input  logic [FW-1:0]           cmd_arg1,
    input  logic                    glyph_valid,
    output logic                    glyph_ready,
    input  logic [GW-1:0]           glyph_data,
    output logic                    err_pulse,
    output logic [ROWS-1:0]         dirty,
    input  logic [ROWS-1:0]         dirty_ack,
    input  logic [$clog2(ROWS)-1:0] rd_sel,
    output logic [COLS*GW-1:0]      rd_cells
);

    localparam int RB = COLS * GW;
    localparam int NW = $clog2(COLS) + 1;

    logic                   apply_en;
    logic [ROWS-1:0]        apply_mask;
    xform_e                 apply_kind;
    logic [NW-1:0]          apply_a;
    logic [NW-1:0]          apply_b;
    logic                   apply_dir;
    logic [GW-1:0]          apply_glyph;
    logic [RB-1:0]          apply_run;
    logic [ROWS*RB-1:0]     rows_flat;
    logic [ROWS-1:0]        changed;

    grs_cmd_ctrl #(.ROWS(ROWS), .COLS(COLS), .GW(GW), .FW(FW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_op      (cmd_op),
        .cmd_row     (cmd_row),
        .cmd_arg0    (cmd_arg0),
        .cmd_arg1    (cmd_arg1),
        .glyph_valid (glyph_valid),
        .glyph_ready (glyph_ready),
        .glyph_data  (glyph_data),
        .err_pulse   (err_pulse),
        .apply_en    (apply_en),
        .apply_mask  (apply_mask),
        .apply_kind  (apply_kind),
        .apply_a     (apply_a),
        .apply_b     (apply_b),
        .apply_dir   (apply_dir),
        .apply_glyph (apply_glyph),
        .apply_run   (apply_run)
    );

    grs_row_bank #(.ROWS(ROWS), .COLS(COLS), .GW(GW)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .apply_en    (apply_en),
        .apply_mask  (apply_mask),
        .apply_kind  (apply_kind),
        .apply_a     (apply_a),
        .apply_b     (apply_b),
        .apply_dir   (apply_dir),
        .apply_glyph (apply_glyph),
        .apply_run   (apply_run),
        .rows_flat   (rows_flat),
        .changed     (changed)
    );

    grs_dirty_track #(.ROWS(ROWS)) u_dirty (
        .clk     (clk),
        .rst_n   (rst_n),
        .changed (changed),
        .ack     (dirty_ack),
        .dirty   (dirty)
    );

    // Select one row for the display driver.
    always_comb begin
        rd_cells = rows_flat[int'(rd_sel)*RB +: RB];
    end

endmodule

// File: rtl/grs_checker.sv
// Cycle-by-cycle properties of the row store, bound to the top module.
module grs_checker #(
    parameter int ROWS = 4,
    parameter int COLS = 32,
    parameter int GW   = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_ready,
    input logic                     glyph_ready,
    input logic                     err_pulse,
    input logic [ROWS-1:0]          dirty,
    input logic [ROWS-1:0]          dirty_ack,
    input logic [ROWS*COLS*GW-1:0]  rows_flat
);

    localparam int RB = COLS * GW;

    // R1: the cycle after reset is clean and ready.
    p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (dirty == '0 && cmd_ready && !glyph_ready));

    // R12: header and glyph handshakes are never open together.
    p_handshake_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && glyph_ready));

    // R9: nothing is stored while glyphs are still streaming.
    p_stream_holds_rows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        glyph_ready |=> $stable(rows_flat));

    // R10: a rejection leaves the store untouched.
    p_err_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> $stable(rows_flat));

    // R10: after a rejection the block is ready for the next header.
    p_err_then_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> cmd_ready);

    // R11: a flag only rises together with a store change.
    p_dirty_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dirty & ~$past(dirty))) |-> !$stable(rows_flat));

    for (genvar r = 0; r < ROWS; r++) begin : g_ack
        // R11: an acknowledged row without a new change drops its flag.
        p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(dirty_ack[r]) && $stable(rows_flat[r*RB +: RB])) |-> !dirty[r]);
    end

endmodule

bind glyph_row_store grs_checker #(.ROWS(ROWS), .COLS(COLS), .GW(GW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .glyph_ready (glyph_ready),
    .err_pulse   (err_pulse),
    .dirty       (dirty),
    .dirty_ack   (dirty_ack),
    .rows_flat   (rows_flat)
);

// File: tb/glyph_row_store_test.sv
`timescale 1ns/1ps
module glyph_row_store_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_op = '0;
    logic [7:0]   cmd_row = '0;
    logic [7:0]   cmd_arg0 = '0;
    logic [7:0]   cmd_arg1 = '0;
    logic         glyph_valid = 1'b0;
    logic         glyph_ready;
    logic [7:0]   glyph_data = '0;
    logic         err_pulse;
    logic [3:0]   dirty;
    logic [3:0]   dirty_ack = '0;
    logic [1:0]   rd_sel = '0;
    logic [255:0] rd_cells;

    int total = 0;
    int bad = 0;
    logic [255:0] model_row [4];
    logic [3:0]   exp_dirty = '0;

    always #2.5 clk = ~clk;

    glyph_row_store uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_arg0(cmd_arg0), .cmd_arg1(cmd_arg1),
        .glyph_valid(glyph_valid), .glyph_ready(glyph_ready), .glyph_data(glyph_data),
        .err_pulse(err_pulse), .dirty(dirty), .dirty_ack(dirty_ack),
        .rd_sel(rd_sel), .rd_cells(rd_cells)
    );

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] row;
        logic [7:0] a0;
        logic [7:0] a1;
        logic       err;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{2'd2, 8'd1,   8'h41, 8'd0,  1'b0},  // R6 fill
        '{2'd2, 8'd2,   8'h42, 8'd0,  1'b0},  // R6 fill
        '{2'd1, 8'd1,   8'd0,  8'd3,  1'b0},  // R4 scroll left
        '{2'd2, 8'd3,   8'h7F, 8'd0,  1'b1},  // R6 reserved fill
        '{2'd2, 8'd3,   8'h7E, 8'd0,  1'b0},  // R6 highest legal
        '{2'd1, 8'd2,   8'd1,  8'd32, 1'b0},  // R5 full scroll
        '{2'd1, 8'd0,   8'd0,  8'd1,  1'b1},  // R8 row 0
        '{2'd1, 8'd1,   8'd2,  8'd1,  1'b1},  // R5 bad direction
        '{2'd1, 8'd1,   8'd0,  8'd0,  1'b1},  // R5 amount 0
        '{2'd1, 8'd1,   8'd1,  8'd33, 1'b1},  // R5 amount 33
        '{2'd3, 8'd5,   8'd0,  8'd0,  1'b1},  // R8 row 5
        '{2'd2, 8'd4,   8'h30, 8'd0,  1'b0},  // R6 fill
        '{2'd3, 8'd4,   8'd0,  8'd0,  1'b0},  // R7 clear one
        '{2'd3, 8'hFF,  8'd0,  8'd0,  1'b0},  // R7 clear all
        '{2'd2, 8'd2,   8'h20, 8'd0,  1'b0},  // R11 no content change
        '{2'd2, 8'hFF,  8'h41, 8'd0,  1'b1}   // R8 all-rows code only for clear
    };

    task automatic check_val(input string req, input string what,
                             input logic [255:0] act, input logic [255:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_rows(input string req);
        for (int r = 0; r < 4; r++) begin
            rd_sel = 2'(r);
            #0.1;
            check_val(req, $sformatf("row index %0d", r), rd_cells, model_row[r]);
        end
    endtask

    task automatic model_apply(input logic [1:0] op, input logic [7:0] row,
                               input logic [7:0] a0, input logic [7:0] a1);
        logic [255:0] o;
        logic hit;
        for (int r = 0; r < 4; r++) begin
            hit = (row == 8'(r + 1)) || (op == 2'd3 && row == 8'hFF);
            if (hit) begin
                o = model_row[r];
                for (int c = 0; c < 32; c++) begin
                    case (op)
                        2'd2: model_row[r][c*8 +: 8] = a0;
                        2'd3: model_row[r][c*8 +: 8] = 8'h20;
                        2'd1: begin
                            if (a0 == 8'd0)
                                model_row[r][c*8 +: 8] = (c + int'(a1) < 32) ? o[(c + int'(a1))*8 +: 8] : 8'h20;
                            else
                                model_row[r][c*8 +: 8] = (c >= int'(a1)) ? o[(c - int'(a1))*8 +: 8] : 8'h20;
                        end
                        default: model_row[r][c*8 +: 8] = o[c*8 +: 8];
                    endcase
                end
            end
        end
    endtask

    task automatic note_dirty(input logic [255:0] snap [4]);
        for (int r = 0; r < 4; r++) begin
            if (model_row[r] !== snap[r]) exp_dirty[r] = 1'b1;
        end
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [7:0] row,
                            input logic [7:0] a0, input logic [7:0] a1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_row = row; cmd_arg0 = a0; cmd_arg1 = a1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic run_imm(input logic [1:0] op, input logic [7:0] row,
                           input logic [7:0] a0, input logic [7:0] a1,
                           input logic exp_err, input string req);
        logic [255:0] snap [4];
        snap = model_row;
        send_hdr(op, row, a0, a1);
        check_val(req, "err_pulse", 256'(err_pulse), 256'(exp_err));
        if (!exp_err) model_apply(op, row, a0, a1);
        note_dirty(snap);
        check_rows(req);
        check_val(req, "dirty", 256'(dirty), 256'(exp_dirty));
    endtask

    task automatic run_write(input logic [7:0] row, input logic [7:0] col, input int n,
                             input logic [255:0] data, input logic hdr_err,
                             input logic run_err, input string req);
        logic [255:0] snap [4];
        snap = model_row;
        send_hdr(2'd0, row, col, 8'(n));
        if (hdr_err || n == 0) begin
            check_val(req, "err_pulse at header", 256'(err_pulse), 256'(hdr_err));
            check_val(req, "no glyph intake", 256'({cmd_ready, glyph_ready}), 256'(2'b10));
        end else begin
            check_val("R12", "ready pair while streaming", 256'({cmd_ready, glyph_ready}), 256'(2'b01));
            for (int i = 0; i < n; i++) begin
                glyph_valid = 1'b1;
                glyph_data  = data[i*8 +: 8];
                @(negedge clk);
            end
            glyph_valid = 1'b0;
            @(negedge clk);
            check_val(req, "err_pulse after run", 256'(err_pulse), 256'(run_err));
            if (!run_err) begin
                for (int i = 0; i < n; i++)
                    model_row[row - 8'd1][(int'(col) + i)*8 +: 8] = data[i*8 +: 8];
            end
        end
        note_dirty(snap);
        check_rows(req);
        check_val(req, "dirty", 256'(dirty), 256'(exp_dirty));
    endtask

    task automatic ack(input logic [3:0] m, input string req);
        @(negedge clk);
        dirty_ack = m;
        @(negedge clk);
        dirty_ack = '0;
        exp_dirty &= ~m;
        check_val(req, "dirty after ack", 256'(dirty), 256'(exp_dirty));
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [255:0] d;
        for (int r = 0; r < 4; r++) model_row[r] = {32{8'h20}};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset contents and handshake state.
        check_rows("R1");
        check_val("R1", "dirty", 256'(dirty), 256'(0));
        check_val("R1", "ready pair", 256'({cmd_ready, glyph_ready}), 256'(2'b10));
        check_val("R1", "err_pulse", 256'(err_pulse), 256'(0));

        // Vector table of direct commands.
        for (int v = 0; v < NV; v++) begin
            run_imm(VT[v].op, VT[v].row, VT[v].a0, VT[v].a1, VT[v].err,
                    $sformatf("table vector %0d", v));
        end

        // R10: strobe lasts a single cycle.
        run_imm(2'd1, 8'd9, 8'd0, 8'd1, 1'b1, "R10 error");
        @(negedge clk);
        check_val("R10", "err_pulse second cycle", 256'(err_pulse), 256'(0));

        ack(4'hF, "R11 ack all");

        // R2: full-row run of distinct glyphs.
        for (int i = 0; i < 32; i++) d[i*8 +: 8] = 8'(8'h41 + i);
        run_write(8'd3, 8'd0, 32, d, 1'b0, 1'b0, "R2 full run");

        // R2: partial run leaves the other cells alone.
        for (int i = 0; i < 32; i++) d[i*8 +: 8] = 8'(8'h30 + i);
        run_write(8'd3, 8'd10, 4, d, 1'b0, 1'b0, "R2 partial run");

        // R4: scroll distinct content both ways.
        run_imm(2'd1, 8'd3, 8'd0, 8'd5, 1'b0, "R4 left by 5");
        run_imm(2'd1, 8'd3, 8'd1, 8'd3, 1'b0, "R4 right by 3");

        // R2: empty run is legal and inert.
        run_write(8'd1, 8'd5, 0, d, 1'b0, 1'b0, "R2 empty run");

        // R3: span limits at the header.
        run_write(8'd2, 8'd30, 3, d, 1'b1, 1'b0, "R3 span past end");
        run_write(8'd2, 8'd32, 0, d, 1'b1, 1'b0, "R3 column 32");
        run_write(8'd2, 8'd0, 33, d, 1'b1, 1'b0, "R3 count 33");
        run_write(8'd2, 8'd29, 3, d, 1'b0, 1'b0, "R3 span ends at column 31");

        // R9: a reserved glyph mid-run rejects the whole run.
        d = '0;
        d[7:0] = 8'h50; d[15:8] = 8'h80; d[23:16] = 8'h51;
        run_write(8'd4, 8'd2, 3, d, 1'b0, 1'b1, "R9 reserved glyph");

        // R11: acknowledge in the same cycle as a change keeps the flag.
        ack(4'hF, "R11 ack all");
        run_imm(2'd2, 8'd1, 8'h55, 8'd0, 1'b0, "R11 make dirty");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_row = 8'd1; cmd_arg0 = 8'h56; cmd_arg1 = 8'd0;
        dirty_ack = 4'b0001;
        @(negedge clk);
        cmd_valid = 1'b0;
        dirty_ack = '0;
        model_apply(2'd2, 8'd1, 8'h56, 8'd0);
        check_val("R11", "set wins over ack", 256'(dirty[0]), 256'(1));
        check_rows("R11");
        ack(4'b0001, "R11 final ack");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule